// File: doc/BRIEF.md
# Banked Interrupt Controller with Wake Masks

This block gathers 128 level-sensitive interrupt lines, arranged as four banks of 32, and reduces them to two processor request outputs: a normal interrupt and a fast interrupt. A source's bank is its number shifted right by five, and its bit within the bank is the low five bits. Each source has an enable bit. Software changes enables only through paired set and clear registers, so read-modify-write races cannot occur. A per-source routing bit sends each enabled source to one of the two outputs.

Before a low-power entry, software writes a hold-off request. The request is granted only when nothing enabled is pending. While the grant holds, a separate per-bank wake mask decides which raw lines may drive the wake output. Software reaches every register through a simple bus with single-cycle writes and registered reads.

Top module: `banked_intc`

## Requirements
- R1: After reset, the control register (0x000) reads 0x80010001 and the priority mask register (0x00C) reads 0x0000001F. Every routing bit reads 1. Enables, wake masks and the hold-off grant read 0, and the irq_o, fiq_o and wake_o outputs are low.
- R2: A write to the enable-set register of bank b (0x100 + 4*b) sets each enable whose data bit is 1 and leaves the others unchanged. A read at that offset returns the bank's enable mask.
- R3: A write to the enable-clear register of bank b (0x180 + 4*b) clears each enable whose data bit is 1 and leaves the others unchanged. A read at that offset also returns the enable mask.
- R4: The routing register of bank b (0x080 + 4*b) is read/write. A bit value of 1 routes the source to irq_o, and a bit value of 0 routes it to fiq_o.
- R5: Each line passes through a two-flop synchronizer. The pending register of bank b (0xD80 + 4*b) reads the synchronized lines ANDed with the enables, so a disabled, asserted source reads 0.
- R6: irq_o is a registered OR of pending sources whose routing bit is 1. fiq_o is a registered OR of pending sources whose routing bit is 0. Each output follows a change on a line within three clock edges.
- R7: The wake mask register of bank b (0xE00 + 4*b) is read/write and does not affect the enables. wake_o is a registered OR of synchronized lines whose mask bit is set, and it is low whenever the hold-off grant is 0.
- R8: A write to the hold-off register (0x014) with bit 0 set grants hold-off only if no enabled source is pending in that cycle; otherwise the grant is refused. A write with bit 0 clear releases the grant. A read returns the grant in bit 0.
- R9: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.
- R10: The control and priority mask registers are 32-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after bus_addr |
| src_in | input | 128 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request while hold-off is granted |

## Verification
The bench writes data words with zero bits to the set and clear registers. A design that treated these registers as plain stores would wipe the other enables. It flips a routing bit while a source is pending. A design with the routing polarity reversed would raise fiq_o instead of irq_o.

It requests hold-off while an enabled source is pending, then again once the source is idle. A design that grants without checking would report 1 at the first request. It arms a wake mask on a source that is not enabled, both before and after the grant. Wake logic gated by enables would stay silent, and wake logic that ignores the grant would fire early. Writes to offsets just past the bank regions check that stray decoding corrupts no enable.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PMASK = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_HOLD  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 12'hD80;
  localparam logic [ADDR_W-1:0] OFS_WMASK = 12'hE00;
  localparam logic [31:0] CTRL_RST  = 32'h8001_0001;
  localparam logic [31:0] PMASK_RST = 32'h0000_001F;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         route_we,
  input  logic         wm_we,
  input  logic [W-1:0] line_sync,
  output logic [W-1:0] en_q,
  output logic [W-1:0] route_q,
  output logic [W-1:0] wm_q,
  output logic [W-1:0] pend,
  output logic         any_irq,
  output logic         any_fiq,
  output logic         any_wake
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '1;
      wm_q    <= '0;
    end else begin
      if (set_we)   en_q    <= en_q | wdata;
      if (clr_we)   en_q    <= en_q & ~wdata;
      if (route_we) route_q <= wdata;
      if (wm_we)    wm_q    <= wdata;
    end
  end

  always_comb begin
    pend     = line_sync & en_q;
    any_irq  = |(pend & route_q);
    any_fiq  = |(pend & ~route_q);
    any_wake = |(line_sync & wm_q);
  end

  AST_SET_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we && wdata == '0) |=> $stable(en_q)); // R2
  AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((en_q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_BITS_DROP: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en_q & $past(wdata)) == '0)); // R3
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [11:0]                   bus_addr,
  input  logic                          bus_wen,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_in,
  output logic                          irq_o,
  output logic                          fiq_o,
  output logic                          wake_o
);
  localparam int NSRC = NUM_BANKS * BANK_W;

  logic [NSRC-1:0]   line_sync;
  logic [BANK_W-1:0] en_a    [NUM_BANKS];
  logic [BANK_W-1:0] route_a [NUM_BANKS];
  logic [BANK_W-1:0] wm_a    [NUM_BANKS];
  logic [BANK_W-1:0] pend_a  [NUM_BANKS];
  logic [NUM_BANKS-1:0] b_irq, b_fiq, b_wake, b_pend;
  logic [31:0] ctrl_q, pmask_q;
  logic        hold_q;
  logic [31:0] rd_next;

  intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst(rst), .d(src_in), .q(line_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4 * b);
    intc_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wdata    (bus_wdata[BANK_W-1:0]),
      .set_we   (bus_wen && bus_addr == OFS_ENSET + STEP),
      .clr_we   (bus_wen && bus_addr == OFS_ENCLR + STEP),
      .route_we (bus_wen && bus_addr == OFS_ROUTE + STEP),
      .wm_we    (bus_wen && bus_addr == OFS_WMASK + STEP),
      .line_sync(line_sync[b*BANK_W +: BANK_W]),
      .en_q     (en_a[b]),
      .route_q  (route_a[b]),
      .wm_q     (wm_a[b]),
      .pend     (pend_a[b]),
      .any_irq  (b_irq[b]),
      .any_fiq  (b_fiq[b]),
      .any_wake (b_wake[b])
    );
    assign b_pend[b] = |pend_a[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      pmask_q <= PMASK_RST;
      hold_q  <= 1'b0;
    end else if (bus_wen) begin
      if (bus_addr == OFS_CTRL)  ctrl_q  <= bus_wdata;
      if (bus_addr == OFS_PMASK) pmask_q <= bus_wdata;
      if (bus_addr == OFS_HOLD)  hold_q  <= bus_wdata[0] && !(|b_pend);
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == OFS_CTRL)  rd_next = ctrl_q;
    if (bus_addr == OFS_PMASK) rd_next = pmask_q;
    if (bus_addr == OFS_HOLD)  rd_next = {31'b0, hold_q};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == OFS_ROUTE + ADDR_W'(4 * b)) rd_next = 32'(route_a[b]);
      if (bus_addr == OFS_ENSET + ADDR_W'(4 * b)) rd_next = 32'(en_a[b]);
      if (bus_addr == OFS_ENCLR + ADDR_W'(4 * b)) rd_next = 32'(en_a[b]);
      if (bus_addr == OFS_PEND  + ADDR_W'(4 * b)) rd_next = 32'(pend_a[b]);
      if (bus_addr == OFS_WMASK + ADDR_W'(4 * b)) rd_next = 32'(wm_a[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_o     <= |b_irq;
      fiq_o     <= |b_fiq;
      wake_o    <= hold_q && (|b_wake);
    end
  end

  AST_WAKE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(hold_q)); // R7
  AST_HOLD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == OFS_HOLD && (|b_pend)) |=> !hold_q); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|b_pend)); // R6
  AST_FIQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|b_pend)); // R6
endmodule

// File: tb/sim_banked_intc.sv
module sim_banked_intc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic         bus_wen = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src_in = '0;
  logic         irq_o, fiq_o, wake_o;
  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  banked_intc u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); check("R1 ctrl", v, 32'h8001_0001);
    rd(12'h00C, v); check("R1 pmask", v, 32'h1F);
    for (int b = 0; b < 4; b++) begin
      rd(12'h080 + 12'(4*b), v); check("R1 route", v, 32'hFFFF_FFFF);
    end
    rd(12'h104, v); check("R1 enable", v, 0);
    rd(12'hE00, v); check("R1 wmask", v, 0);
    rd(12'h014, v); check("R1 hold", v, 0);
    check("R1 outputs", {29'b0, irq_o, fiq_o, wake_o}, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(12'h104, 32'h0000_00F0);
    wr(12'h104, 32'h0);
    rd(12'h104, v); check("R2 set/zero", v, 32'hF0);
    wr(12'h104, 32'h0000_0100);
    rd(12'h104, v); check("R2 set accumulates", v, 32'h1F0);
    wr(12'h184, 32'h0000_0130);
    rd(12'h104, v); check("R3 clear", v, 32'hC0);
    wr(12'h184, 32'h0);
    rd(12'h184, v); check("R3 clear zero/readback", v, 32'hC0);
    rd(12'h100, v); check("R2 other bank", v, 0);
  endtask

  task automatic t_route();
    logic [31:0] v;
    src_in[3] = 1'b1;
    settle();
    rd(12'hD80, v); check("R5 disabled not pending", v, 0);
    check("R6 disabled no irq", {30'b0, irq_o, fiq_o}, 0);
    wr(12'h108, 32'h40);
    src_in[70] = 1'b1;
    settle();
    rd(12'hD88, v); check("R5 pending", v, 32'h40);
    check("R6 irq route", {30'b0, irq_o, fiq_o}, 32'h2);
    wr(12'h088, ~32'h40);
    settle();
    check("R4 fiq route", {30'b0, irq_o, fiq_o}, 32'h1);
    rd(12'h088, v); check("R4 readback", v, ~32'h40);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(12'h014, 32'h1);
    rd(12'h014, v); check("R8 refused", v, 0);
    wr(12'hE00, 32'h8);
    settle();
    check("R7 no wake without grant", {31'b0, wake_o}, 0);
    rd(12'h100, v); check("R7 wmask leaves enables", v, 0);
    src_in[70] = 1'b0;
    settle();
    check("R6 idle", {30'b0, irq_o, fiq_o}, 0);
    wr(12'h014, 32'h1);
    rd(12'h014, v); check("R8 granted", v, 1);
    settle();
    check("R7 wake active", {31'b0, wake_o}, 1);
    wr(12'h014, 32'h0);
    settle();
    check("R8 release", {31'b0, wake_o}, 0);
    rd(12'hE00, v); check("R7 wmask readback", v, 32'h8);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h040, 32'hDEAD_BEEF);
    rd(12'h040, v); check("R9 unmapped read", v, 0);
    wr(12'h190, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h104, v); check("R9 enables kept", v, 32'hC0);
    rd(12'h10C, v); check("R9 bank3 kept", v, 0);
    rd(12'h300, v); check("R9 empty offset", v, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(12'h00C, 32'h0A);
    rd(12'h00C, v); check("R10 pmask", v, 32'h0A);
    wr(12'h000, 32'h0000_1234);
    rd(12'h000, v); check("R10 ctrl", v, 32'h1234);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_route();
    t_hold();
    t_unmapped();
    t_ctrl();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule